// File: doc/BRIEF.md
# Address Translation Mode Front End

This block takes one virtual-address request per handshake and decides, before any TLB lookup, which way the address is translated. If the core runs in direct mode with paging off, the address passes straight through, cut to the physical width. Otherwise a set of direct-map windows is searched. Each window is enabled per privilege level and names a virtual segment. A hit yields the physical address at once. If no window hits, an upper-bits canonical check decides between a bad-address result and handing the request on to the TLB path.

There is a 64-bit mode and a 32-bit mode. In 64-bit mode a window matches on the top nibble of the address, and a hit keeps the low physical bits unchanged. In 32-bit mode a window matches on the top three bits of a 32-bit address, and a hit replaces those bits with the window's physical segment. The result leaves through a registered valid/ready output stage.

Top module: `xlate_mode_front`

## Requirements
- R1: With direct mode on and paging off, the result kind is DIRECT (code 0) and the address is the effective VA masked to PHYS_W bits, whatever the windows hold. Every other combination of the two mode bits is treated as mapped.
- R2: Window bit 0 enables the window at privilege level 0, and bit 3 enables it at level 3. At levels 1 and 2 no window ever applies.
- R3: In 64-bit mode, an enabled window matches when its bits [63:60] equal VA[63:60]. The result is WINDOW (code 1) with address VA[PHYS_W-1:0], zero-extended.
- R4: In 32-bit mode, an enabled window matches when its bits [31:29] equal VA[31:29]. The address is {window[27:25], VA[28:0]}, zero-extended.
- R5: When several windows match, the one with the lowest index supplies the result.
- R6: A window hit wins even when the address would fail the canonical check.
- R7: In 64-bit mode with no hit, if VA[63:VIRT_W] is neither all zeros nor all ones, the kind is BADADDR (code 2) and the address is 0. The bad_fetch output then equals the request's fetch flag; for every other kind it is 0. VA bit VIRT_W-1 plays no part in this check.
- R8: With no hit and a canonical address, the kind is TLB (code 3) and the address is the effective VA.
- R9: In 32-bit mode, VA[63:32] is ignored (treated as zero), so the result is never BADADDR.
- R10: in_ready is high exactly when the output is empty or being taken. An accepted request appears on the output on the next cycle. While out_valid is high and out_ready is low, the output holds and does not change.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_va | input | 64 | Virtual address |
| in_mode64 | input | 1 | 1: 64-bit addressing, 0: 32-bit addressing |
| in_direct | input | 1 | Direct mode bit |
| in_paging | input | 1 | Paging enable bit |
| in_lvl | input | 2 | Current privilege level |
| in_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| in_win | input | NUM_WIN*64 | Window registers, window 0 in the low 64 bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_kind | output | 2 | 0 DIRECT, 1 WINDOW, 2 BADADDR, 3 TLB |
| out_addr | output | 64 | Physical address, or the VA forwarded to the TLB path |
| out_bad_fetch | output | 1 | Bad address came from a fetch |

## Verification
The functions that can collide in one cycle are a window hit and a failed canonical check: one address with a matching top nibble and non-canonical upper bits exercises both. The bench provokes this on purpose and also lets random stimulus bias top nibbles toward the window segments. It judges the result by the reference model's priority, under which the window must win. A second overlap, a new acceptance in the same cycle the previous result is taken, is exercised throughout by random out_ready stalls, and both the hold and the refill are compared on every clock.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int ADDR_W    = 64;
    localparam int SEG64_LSB = 60;
    localparam int SEG64_W   = 4;
    localparam int SEG32_LSB = 29;
    localparam int SEG32_W   = 3;
    localparam int PSEG_LSB  = 25;
    localparam int EN_L0_BIT = 0;
    localparam int EN_L3_BIT = 3;

    typedef enum logic [1:0] {
        KIND_DIRECT  = 2'd0,
        KIND_WINDOW  = 2'd1,
        KIND_BADADDR = 2'd2,
        KIND_TLB     = 2'd3
    } xlate_kind_e;

    typedef struct packed {
        xlate_kind_e       kind;
        logic [ADDR_W-1:0] addr;
        logic              bad_fetch;
    } xlate_res_t;

    // Per-level enable bit of a window; levels 1 and 2 select nothing.
    function automatic logic lvl_enable(input logic [ADDR_W-1:0] win,
                                        input logic [1:0]        lvl);
        logic en;
        case (lvl)
            2'd0:    en = win[EN_L0_BIT];
            2'd3:    en = win[EN_L3_BIT];
            default: en = 1'b0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/xlate_win_cmp.sv
module xlate_win_cmp
    import xlate_pkg::*;
#(
    parameter int PHYS_W = 48
) (
    input  logic [ADDR_W-1:0] va,
    input  logic              mode64,
    input  logic [1:0]        lvl,
    input  logic [ADDR_W-1:0] win,
    output logic              hit,
    output logic [ADDR_W-1:0] pa
);

    logic en;
    logic seg_eq;
    logic [ADDR_W-1:0] pa_wide;
    logic [ADDR_W-1:0] pa_narrow;

    assign en = lvl_enable(win, lvl);

    assign seg_eq = mode64
        ? (win[SEG64_LSB +: SEG64_W] == va[SEG64_LSB +: SEG64_W])
        : (win[SEG32_LSB +: SEG32_W] == va[SEG32_LSB +: SEG32_W]);

    assign hit = en && seg_eq;

    assign pa_wide   = ADDR_W'(va[PHYS_W-1:0]);
    assign pa_narrow = ADDR_W'({win[PSEG_LSB +: SEG32_W], va[SEG32_LSB-1:0]});
    assign pa        = mode64 ? pa_wide : pa_narrow;

endmodule

// File: rtl/xlate_canon_chk.sv
module xlate_canon_chk #(
    parameter int HI_W = 16
) (
    input  logic            mode64,
    input  logic [HI_W-1:0] hi_bits,
    output logic            ok
);

    assign ok = !mode64 || (hi_bits == '0) || (hi_bits == '1);

endmodule

// File: rtl/xlate_out_reg.sv
module xlate_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_data  <= in_data;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid);

    // R10
    stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(out_data));

endmodule

// File: rtl/xlate_mode_front.sv
module xlate_mode_front
    import xlate_pkg::*;
#(
    parameter int VIRT_W  = 48,
    parameter int PHYS_W  = 48,
    parameter int NUM_WIN = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [63:0]                in_va,
    input  logic                       in_mode64,
    input  logic                       in_direct,
    input  logic                       in_paging,
    input  logic [1:0]                 in_lvl,
    input  logic                       in_fetch,
    input  logic [NUM_WIN*64-1:0]      in_win,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [1:0]                 out_kind,
    output logic [63:0]                out_addr,
    output logic                       out_bad_fetch
);

    localparam int HI_W  = ADDR_W - VIRT_W;
    localparam int RES_W = $bits(xlate_res_t);

    logic [ADDR_W-1:0]                 va_eff;
    logic [NUM_WIN-1:0]                hit;
    logic [NUM_WIN-1:0][ADDR_W-1:0]    win_pa;
    logic [ADDR_W-1:0]                 sel_pa;
    logic                              any_hit;
    logic                              canon_ok;
    logic                              direct_mode;
    xlate_res_t                        res_d;
    xlate_res_t                        res_q;
    logic [RES_W-1:0]                  res_q_bits;

    // 32-bit mode sees only the low word of the address.
    assign va_eff      = in_mode64 ? in_va : {32'b0, in_va[31:0]};
    assign direct_mode = in_direct && !in_paging;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        xlate_win_cmp #(.PHYS_W(PHYS_W)) u_cmp (
            .va     (va_eff),
            .mode64 (in_mode64),
            .lvl    (in_lvl),
            .win    (in_win[g*ADDR_W +: ADDR_W]),
            .hit    (hit[g]),
            .pa     (win_pa[g])
        );
    end

    xlate_canon_chk #(.HI_W(HI_W)) u_canon (
        .mode64  (in_mode64),
        .hi_bits (va_eff[ADDR_W-1:VIRT_W]),
        .ok      (canon_ok)
    );

    // Lowest index wins: scan downward so the last write is window 0.
    always_comb begin
        sel_pa  = '0;
        any_hit = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                sel_pa  = win_pa[i];
            end
        end
    end

    always_comb begin
        res_d = '0;
        if (direct_mode) begin
            res_d.kind = KIND_DIRECT;
            res_d.addr = ADDR_W'(va_eff[PHYS_W-1:0]);
        end else if (any_hit) begin
            res_d.kind = KIND_WINDOW;
            res_d.addr = sel_pa;
        end else if (!canon_ok) begin
            res_d.kind      = KIND_BADADDR;
            res_d.bad_fetch = in_fetch;
        end else begin
            res_d.kind = KIND_TLB;
            res_d.addr = va_eff;
        end
    end

    xlate_out_reg #(.W(RES_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (res_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (res_q_bits)
    );

    assign res_q         = xlate_res_t'(res_q_bits);
    assign out_kind      = res_q.kind;
    assign out_addr      = res_q.addr;
    assign out_bad_fetch = res_q.bad_fetch;

    // R1
    direct_kind_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_direct && !in_paging
        |=> out_valid && out_kind == KIND_DIRECT);

    // R6
    win_first_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !(in_direct && !in_paging) && (|hit)
        |=> out_valid && out_kind == KIND_WINDOW);

    // R9
    no_bad32_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_mode64
        |=> out_kind != KIND_BADADDR);

endmodule

// File: tb/xlate_mode_front_tb_top.sv
`timescale 1ns/1ps
module xlate_mode_front_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_va = '0;
    logic         in_mode64 = 1'b1;
    logic         in_direct = 1'b0;
    logic         in_paging = 1'b1;
    logic [1:0]   in_lvl = 2'd0;
    logic         in_fetch = 1'b0;
    logic [255:0] in_win = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [1:0]   out_kind;
    logic [63:0]  out_addr;
    logic         out_bad_fetch;

    xlate_mode_front dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_va(in_va), .in_mode64(in_mode64),
        .in_direct(in_direct), .in_paging(in_paging),
        .in_lvl(in_lvl), .in_fetch(in_fetch), .in_win(in_win),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_addr(out_addr),
        .out_bad_fetch(out_bad_fetch)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] wv [4];

    bit          m_valid = 0;
    int          m_kind = 0;
    logic [63:0] m_addr = '0;
    bit          m_fetch = 0;
    string       m_tag = "";

    localparam logic [63:0] MASK48 = 64'h0000_FFFF_FFFF_FFFF;

    function automatic logic [63:0] mkwin(input logic [3:0] s64, input logic [2:0] s32,
                                          input logic [2:0] ps, input bit e0, input bit e3);
        return {s64, 28'b0, s32, 1'b0, ps, 21'b0, e3, 2'b0, e0};
    endfunction

    task automatic ref_model(input logic [63:0] va, input bit m64, input bit da, input bit pg,
                             input int lvl, input bit fetch, output int kind,
                             output logic [63:0] addr, output bit bf, output string tag);
        logic [63:0] v;
        bit found;
        v = m64 ? va : (va & 64'h0000_0000_FFFF_FFFF);
        bf = 0; addr = '0; found = 0; kind = 0; tag = "";
        if (da && !pg) begin
            kind = 0; addr = v & MASK48; tag = "R1"; found = 1;
        end
        for (int i = 0; i < 4; i++) begin
            bit en, m;
            en = (lvl == 0) ? wv[i][0] : (lvl == 3) ? wv[i][3] : 1'b0;
            m  = m64 ? (wv[i][63:60] == v[63:60]) : (wv[i][31:29] == v[31:29]);
            if (!found && en && m) begin
                found = 1; kind = 1;
                if (m64) begin addr = v & MASK48; tag = "R3"; end
                else begin addr = {32'b0, wv[i][27:25], v[28:0]}; tag = "R4"; end
            end
        end
        if (!found) begin
            if (m64 && !(v[63:48] == 16'h0000 || v[63:48] == 16'hFFFF)) begin
                kind = 2; bf = fetch; tag = "R7";
            end else begin
                kind = 3; addr = v; tag = "R8";
            end
        end
    endtask

    task automatic compare_out();
        checks++;
        if (out_valid !== m_valid) begin
            errors++;
            $display("FAIL R10 out_valid act=%0b exp=%0b", out_valid, m_valid);
        end else if (m_valid) begin
            checks++;
            if (out_kind !== 2'(m_kind) || out_addr !== m_addr || out_bad_fetch !== m_fetch) begin
                errors++;
                $display("FAIL %s kind/addr/badf act=%0d/%h/%0b exp=%0d/%h/%0b",
                         m_tag, out_kind, out_addr, out_bad_fetch, m_kind, m_addr, m_fetch);
            end
        end
    endtask

    task automatic step(input logic [63:0] va, input bit m64, input bit da, input bit pg,
                        input int lvl, input bit fetch, input bit iv, input bit ordy,
                        input string tag);
        bit acc;
        int k; logic [63:0] a; bit b; string t;
        @(negedge clk);
        compare_out();
        in_va = va; in_mode64 = m64; in_direct = da; in_paging = pg;
        in_lvl = 2'(lvl); in_fetch = fetch; in_valid = iv; out_ready = ordy;
        in_win = {wv[3], wv[2], wv[1], wv[0]};
        #1;
        checks++;
        if (in_ready !== (!m_valid || ordy)) begin
            errors++;
            $display("FAIL R10 in_ready act=%0b exp=%0b", in_ready, (!m_valid || ordy));
        end
        acc = iv && (!m_valid || ordy);
        if (acc) begin
            ref_model(va, m64, da, pg, lvl, fetch, k, a, b, t);
            m_valid = 1; m_kind = k; m_addr = a; m_fetch = b;
            m_tag = (tag != "") ? tag : t;
        end else if (ordy) begin
            m_valid = 0;
        end
    endtask

    task automatic clear_win();
        for (int i = 0; i < 4; i++) wv[i] = mkwin(4'h0, 3'h0, 3'h0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_win();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 valid/ready act=%0b/%0b exp=0/1", out_valid, in_ready);
        end

        // R1: direct mode beats a matching window
        for (int i = 0; i < 4; i++) wv[i] = mkwin(4'hF, 3'h7, 3'h1, 1, 1);
        step(64'hFFFF_8000_1234_5678, 1, 1, 0, 0, 0, 1, 1, "R1");
        step(64'h1234_5678_9ABC_DEF0, 0, 1, 0, 3, 1, 1, 1, "R1");

        // R3: 64-bit window hit
        clear_win();
        wv[0] = mkwin(4'h0, 3'h0, 3'h0, 1, 0);
        step(64'h0000_0012_3456_7890, 1, 0, 1, 0, 0, 1, 1, "R3");

        // R6: window hit on a non-canonical address
        clear_win();
        wv[1] = mkwin(4'h9, 3'h0, 3'h0, 1, 0);
        step(64'h9000_1111_2222_3333, 1, 0, 1, 0, 1, 1, 1, "R6");

        // R2: per-level enables
        clear_win();
        wv[2] = mkwin(4'h9, 3'h0, 3'h0, 1, 0);
        step(64'h9000_0000_0000_0040, 1, 0, 1, 3, 0, 1, 1, "R2");
        wv[2] = mkwin(4'h9, 3'h0, 3'h0, 0, 1);
        step(64'h9000_0000_0000_0040, 1, 0, 1, 3, 0, 1, 1, "R2");
        step(64'h9000_0000_0000_0040, 1, 0, 1, 0, 0, 1, 1, "R2");
        wv[2] = mkwin(4'h9, 3'h0, 3'h0, 1, 1);
        step(64'h9000_0000_0000_0040, 1, 0, 1, 1, 0, 1, 1, "R2");
        step(64'h9000_0000_0000_0040, 1, 0, 1, 2, 1, 1, 1, "R2");

        // R4: 32-bit segment replacement
        clear_win();
        wv[3] = mkwin(4'h0, 3'h5, 3'h2, 1, 0);
        step(64'h0000_0000_A123_4567, 0, 0, 1, 0, 0, 1, 1, "R4");

        // R5: lowest index wins
        clear_win();
        wv[0] = mkwin(4'h0, 3'h5, 3'h2, 1, 1);
        wv[2] = mkwin(4'h0, 3'h5, 3'h6, 1, 1);
        step(64'h0000_0000_A123_4567, 0, 0, 1, 0, 0, 1, 1, "R5");
        wv[0] = mkwin(4'h0, 3'h5, 3'h2, 0, 0);
        wv[1] = mkwin(4'h0, 3'h5, 3'h3, 0, 1);
        step(64'h0000_0000_A123_4567, 0, 0, 1, 3, 0, 1, 1, "R5");

        // R9: upper word ignored in 32-bit mode
        clear_win();
        step(64'hDEAD_BEEF_0123_4567, 0, 0, 1, 0, 1, 1, 1, "R9");
        step(64'h1234_0000_FFFF_0000, 0, 0, 1, 3, 0, 1, 1, "R9");

        // R7: non-canonical, fetch flag
        step(64'h1234_0000_0000_0000, 1, 0, 1, 0, 1, 1, 1, "R7");
        step(64'h1234_0000_0000_0000, 1, 0, 1, 0, 0, 1, 1, "R7");
        step(64'h0001_0000_0000_0000, 1, 0, 1, 3, 1, 1, 1, "R7");
        step(64'h7FFF_FFFF_FFFF_FFFF, 1, 0, 1, 0, 0, 1, 1, "R7");

        // R8: canonical forward, bit 47 free, non-direct mode combinations
        step(64'h0000_8000_0000_0000, 1, 0, 1, 0, 0, 1, 1, "R8");
        step(64'hFFFF_0123_4567_89AB, 1, 0, 1, 0, 1, 1, 1, "R8");
        step(64'h0000_0000_0000_1000, 1, 0, 0, 0, 0, 1, 1, "R8");
        step(64'h0000_0000_0000_2000, 1, 1, 1, 0, 0, 1, 1, "R8");

        // R10: stall with pending requests, then release
        step(64'h0000_0000_0000_3000, 1, 0, 1, 0, 0, 1, 0, "R10");
        step(64'h0000_0000_0000_4000, 1, 0, 1, 0, 0, 1, 0, "R10");
        step(64'h0000_0000_0000_5000, 1, 0, 1, 0, 0, 1, 0, "R10");
        step(64'h0000_0000_0000_6000, 1, 0, 1, 0, 0, 1, 1, "R10");
        step(64'h0000_0000_0000_7000, 1, 0, 1, 0, 0, 0, 0, "R10");
        step(64'h0000_0000_0000_8000, 1, 0, 1, 0, 0, 0, 1, "R10");

        // Random traffic with stalls, biased toward window and canonical hits
        for (int n = 0; n < 600; n++) begin
            logic [63:0] va;
            int lvl;
            bit m64, da, pg;
            for (int i = 0; i < 4; i++)
                wv[i] = mkwin(4'($urandom_range(0, 3) * 5), 3'($urandom_range(0, 7)),
                              3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                              1'($urandom_range(0, 1)));
            va = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: va[63:48] = 16'h0000;
                1: va[63:48] = 16'hFFFF;
                2: va[63:60] = 4'($urandom_range(0, 3) * 5);
                default: ;
            endcase
            lvl = $urandom_range(0, 3);
            m64 = 1'($urandom_range(0, 1));
            da  = ($urandom_range(0, 3) == 0);
            pg  = ($urandom_range(0, 3) != 0);
            step(va, m64, da, pg, lvl, 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 4) != 0), ($urandom_range(0, 3) != 0), "");
        end

        step('0, 1, 0, 1, 0, 0, 0, 1, "");
        step('0, 1, 0, 1, 0, 0, 0, 1, "");
        @(negedge clk);
        compare_out();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule